// File: doc/BRIEF.md
# Hash Bucket Fetch and Search

This block completes one routing lookup once the bucket that may hold the matching prefix is already known. It takes a bucket number and a lookup key of up to 24 bits. It reads that bucket from an external synchronous memory as a fixed run of 72-bit words and rebuilds the 40-bit entries packed across those words. It then compares every occupied entry with the key and returns a hit flag and a 16-bit output port.

Every bucket has the same capacity, and exactly one bucket is streamed per lookup. The read therefore always takes `ceil(40*SLOTS/72)` memory cycles, and every lookup has the same latency. A new lookup may start in the cycle that issues the final read of the previous one, so the memory port can be kept busy without gaps. Results leave in the order the requests arrived.

Top module: `bkt_search`

## Requirements
- R1: Bucket `b` occupies memory words `b*BEATS` up to `b*BEATS+BEATS-1`, with `BEATS = ceil(40*SLOTS/72)` (3 for the default of 5 slots). A lookup asserts `mem_rd_en` for exactly BEATS consecutive cycles, and the address rises by one in each of those cycles.
- R2: `rsp_valid` pulses for one cycle, BEATS+1 clock edges after the edge that accepts the request. The latency is the same for a hit and for a miss.
- R3: Slot `i` of a bucket occupies bits `40*i` up to `40*i+39` of the concatenated bucket words, where word `b*BEATS+j` supplies bits `72*j` up to `72*j+71`. Bits 15:0 of a slot hold the port and bits 39:16 hold the prefix. An entry split across two words is reassembled correctly.
- R4: A lookup whose key equals the prefix of an occupied slot returns `rsp_hit`=1 and that slot's port.
- R5: A slot whose 40 bits are all zero is empty and never hits, even for key 0. A slot with prefix 0 and a nonzero port is occupied and does hit.
- R6: When several slots match the key, the lowest-numbered slot supplies the port.
- R7: A miss returns `rsp_hit`=0 and `rsp_port`=0.
- R8: `req_ready` is high while the block is idle and during the cycle that issues a lookup's final read. A request accepted there starts reading on the next cycle, and its response follows the earlier one by exactly BEATS cycles.
- R9: After a synchronous active-low reset, `rsp_valid`=0, `mem_rd_en`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_bucket | input | BKT_W (8) | Bucket number to fetch |
| req_key | input | KEY_W (24) | Prefix to search for |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | A matching occupied slot was found |
| rsp_port | output | PORT_W (16) | Port of the winning slot, 0 on a miss |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W (10) | Memory word address |
| mem_rd_data | input | WORD_W (72) | Read data, valid the cycle after the strobe |

## Verification
The hardest case to reach is a request that arrives in the same cycle as the final read of the previous bucket. The words of the two buckets then follow each other with no gap, and reassembly must not mix them. The bench reaches this case by presenting a second request while the first one is still being read, and holding it until `req_ready` rises. It then checks the ports, the order and the exact spacing of both results. Entries split across word boundaries are placed in slots 1 and 3 on purpose. Duplicate prefixes and all-zero slots are placed in the same bucket as live entries.

// File: rtl/bkt_pkg.sv
// Package: shared helper functions for the bucket fetch and search block.
// Assumes: all arguments are positive constants that are known at elaboration.
package bkt_pkg;

    // Ceiling division, used to size the burst length and the buffers.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Width of a counter that holds values 0 .. n-1, never less than one bit.
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bkt_issue.sv
// Module: bkt_issue
// Accepts one lookup request and issues BEATS consecutive word reads for
// the chosen bucket. It passes the beat index, a last-beat flag and the key
// along with each read, so that the data side can be matched to them.
// Assumes: the memory returns read data exactly one cycle after the strobe.
module bkt_issue
    import bkt_pkg::*;
#(
    parameter int BKT_W  = 8,
    parameter int KEY_W  = 24,
    parameter int BEATS  = 3,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BKT_W-1:0]  req_bucket,
    input  logic [KEY_W-1:0]  req_key,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [cnt_w(BEATS)-1:0] rd_beat,
    output logic              rd_last,
    output logic [KEY_W-1:0]  rd_key
);
    localparam int BT_W = cnt_w(BEATS);
    localparam logic [BT_W-1:0] LAST_BEAT = BT_W'(BEATS - 1);

    logic              busy_q;
    logic [BT_W-1:0]   beat_q;
    logic [ADDR_W-1:0] base_q;
    logic [KEY_W-1:0]  key_q;

    // Request hand-off: ready when idle or when issuing the final beat.
    always_comb begin
        rd_last   = busy_q && (beat_q == LAST_BEAT);
        req_ready = !busy_q || rd_last;
    end

    // Burst sequencer: load a new bucket or step through the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= '0;
            base_q <= '0;
            key_q  <= '0;
        end else if (req_valid && req_ready) begin
            busy_q <= 1'b1;
            beat_q <= '0;
            base_q <= ADDR_W'(req_bucket) * ADDR_W'(BEATS);
            key_q  <= req_key;
        end else if (busy_q) begin
            if (rd_last) begin
                busy_q <= 1'b0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Memory-side outputs of the current beat.
    always_comb begin
        rd_en   = busy_q;
        rd_addr = base_q + ADDR_W'(beat_q);
        rd_beat = beat_q;
        rd_key  = key_q;
    end
endmodule

// File: rtl/bkt_gather.sv
// Module: bkt_gather
// Matches each returning memory word with its beat tag, keeps the earlier
// words of the bucket, and presents the whole bucket as one flat vector in
// the cycle its final word arrives. Word j sits at bits WORD_W*j.
// Assumes: one-cycle read latency and no gap between the beats of a bucket.
module bkt_gather
    import bkt_pkg::*;
#(
    parameter int KEY_W  = 24,
    parameter int WORD_W = 72,
    parameter int BEATS  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tag_en,
    input  logic [cnt_w(BEATS)-1:0] tag_beat,
    input  logic                    tag_last,
    input  logic [KEY_W-1:0]        tag_key,
    input  logic [WORD_W-1:0]       word,
    output logic                    bkt_vld,
    output logic [KEY_W-1:0]        bkt_key,
    output logic [BEATS*WORD_W-1:0] bkt_flat
);
    localparam int BT_W = cnt_w(BEATS);

    logic             d_en_q;
    logic [BT_W-1:0]  d_beat_q;
    logic             d_last_q;
    logic [KEY_W-1:0] d_key_q;

    // Tag delay: align the beat tags with the data arriving one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_en_q   <= 1'b0;
            d_beat_q <= '0;
            d_last_q <= 1'b0;
            d_key_q  <= '0;
        end else begin
            d_en_q   <= tag_en;
            d_beat_q <= tag_beat;
            d_last_q <= tag_last;
            d_key_q  <= tag_key;
        end
    end

    assign bkt_vld = d_en_q && d_last_q;
    assign bkt_key = d_key_q;

    generate
        if (BEATS > 1) begin : g_multi
            logic [WORD_W-1:0] hold_q [BEATS-1];
            for (genvar j = 0; j < BEATS - 1; j++) begin : g_word
                // Word store: capture beat j of the bucket being read.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        hold_q[j] <= '0;
                    end else if (d_en_q && (d_beat_q == BT_W'(j))) begin
                        hold_q[j] <= word;
                    end
                end
                assign bkt_flat[j*WORD_W +: WORD_W] = hold_q[j];
            end
            assign bkt_flat[(BEATS-1)*WORD_W +: WORD_W] = word;
        end else begin : g_single
            assign bkt_flat = word;
        end
    endgenerate
endmodule

// File: rtl/bkt_match.sv
// Module: bkt_match
// Splits a flat bucket into SLOTS entries of {prefix, port}. It compares
// every occupied entry with the key and reports the lowest matching slot.
// An entry whose bits are all zero is treated as empty.
// Assumes: FLAT_W is at least SLOTS*(KEY_W+PORT_W).
module bkt_match #(
    parameter int KEY_W  = 24,
    parameter int PORT_W = 16,
    parameter int SLOTS  = 5,
    parameter int FLAT_W = 216
) (
    input  logic [FLAT_W-1:0] flat,
    input  logic [KEY_W-1:0]  key,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam int ENT_W = KEY_W + PORT_W;

    // Priority search: scan from the top so that the lowest slot wins.
    always_comb begin
        hit  = 1'b0;
        port = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if ((|flat[i*ENT_W +: ENT_W]) &&
                (flat[i*ENT_W + PORT_W +: KEY_W] == key)) begin
                hit  = 1'b1;
                port = flat[i*ENT_W +: PORT_W];
            end
        end
    end
endmodule

// File: rtl/bkt_search.sv
// Module: bkt_search (top)
// Fetches one fixed-size bucket per lookup from a synchronous memory and
// searches it for the key. The result is registered and pulsed on rsp_valid
// BEATS+1 edges after the request is accepted, in request order.
// Assumes: the memory has a read latency of one cycle and no stalls.
module bkt_search
    import bkt_pkg::*;
#(
    parameter int BKT_W  = 8,
    parameter int KEY_W  = 24,
    parameter int PORT_W = 16,
    parameter int WORD_W = 72,
    parameter int SLOTS  = 5,
    parameter int BEATS  = cdiv(SLOTS * (KEY_W + PORT_W), WORD_W),
    parameter int ADDR_W = BKT_W + cnt_w(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BKT_W-1:0]  req_bucket,
    input  logic [KEY_W-1:0]  req_key,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_port,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rd_data
);
    localparam int BT_W   = cnt_w(BEATS);
    localparam int FLAT_W = BEATS * WORD_W;

    logic [BT_W-1:0]   iss_beat;
    logic              iss_last;
    logic [KEY_W-1:0]  iss_key;
    logic              bkt_vld;
    logic [KEY_W-1:0]  bkt_key;
    logic [FLAT_W-1:0] bkt_flat;
    logic              m_hit;
    logic [PORT_W-1:0] m_port;

    bkt_issue #(
        .BKT_W(BKT_W), .KEY_W(KEY_W), .BEATS(BEATS), .ADDR_W(ADDR_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bucket(req_bucket), .req_key(req_key),
        .rd_en(mem_rd_en), .rd_addr(mem_addr),
        .rd_beat(iss_beat), .rd_last(iss_last), .rd_key(iss_key)
    );

    bkt_gather #(
        .KEY_W(KEY_W), .WORD_W(WORD_W), .BEATS(BEATS)
    ) u_gather (
        .clk(clk), .rst_n(rst_n),
        .tag_en(mem_rd_en), .tag_beat(iss_beat), .tag_last(iss_last),
        .tag_key(iss_key), .word(mem_rd_data),
        .bkt_vld(bkt_vld), .bkt_key(bkt_key), .bkt_flat(bkt_flat)
    );

    bkt_match #(
        .KEY_W(KEY_W), .PORT_W(PORT_W), .SLOTS(SLOTS), .FLAT_W(FLAT_W)
    ) u_match (
        .flat(bkt_flat), .key(bkt_key), .hit(m_hit), .port(m_port)
    );

    // Result register: one pulse per bucket, with the port forced to zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_port  <= '0;
        end else begin
            rsp_valid <= bkt_vld;
            rsp_hit   <= bkt_vld && m_hit;
            rsp_port  <= (bkt_vld && m_hit) ? m_port : '0;
        end
    end
endmodule

// File: rtl/bkt_search_chk.sv
// Module: bkt_search_chk
// Protocol checker bound to bkt_search. It checks the burst shape, the
// response timing and the miss encoding at the ports.
module bkt_search_chk #(
    parameter int ADDR_W = 10,
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PORT_W-1:0] rsp_port
);
    AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en && !req_ready |=> mem_rd_en); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en && !req_ready |=> mem_addr == $past(mem_addr) + 1'b1); // R1
    AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en && req_ready |-> ##2 rsp_valid); // R2
    AST_RSP_HAS_BURST: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(mem_rd_en && req_ready, 2)); // R2
    AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_hit |-> rsp_port == '0); // R7
    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_ready |=> mem_rd_en); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> !rsp_hit); // R4
endmodule

bind bkt_search bkt_search_chk #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_port(rsp_port)
);

// File: tb/bkt_search_bench.sv
`timescale 1ns/1ps
// Directed bench for bkt_search. A behavioural memory answers reads one
// cycle late. Monitors log every response and read address with a cycle stamp.
module bkt_search_bench;
    localparam int BKT_W = 8, KEY_W = 24, PORT_W = 16, WORD_W = 72, SLOTS = 5;
    localparam int BEATS = 3, ADDR_W = 10, DEPTH = 256 * BEATS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [BKT_W-1:0] req_bucket = '0;
    logic [KEY_W-1:0] req_key = '0;
    logic rsp_valid, rsp_hit;
    logic [PORT_W-1:0] rsp_port;
    logic mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_rd_data;

    logic [WORD_W-1:0] mem [DEPTH];

    int checks = 0, errors = 0, cyc = 0, acc_cyc = 0;
    int n_rsp = 0, n_rd = 0;
    logic          log_hit  [64];
    logic [15:0]   log_port [64];
    int            log_cyc  [64];
    int            log_addr [64];
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    bkt_search u_bkt_search (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bucket(req_bucket), .req_key(req_key), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_port(rsp_port), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    // Behavioural memory with one-cycle read latency.
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: log responses and read addresses away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && n_rsp < 64) begin
            log_hit[n_rsp]  = rsp_hit;
            log_port[n_rsp] = rsp_port;
            log_cyc[n_rsp]  = cyc;
            n_rsp++;
        end
        if (rst_n && mem_rd_en && n_rd < 64) begin
            log_addr[n_rd] = int'(mem_addr);
            n_rd++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_bucket(input int b);
        for (int j = 0; j < BEATS; j++) mem[b*BEATS + j] = '0;
    endtask

    // Place {prefix, port} into slot s of bucket b, LSB first across words.
    task automatic put_entry(input int b, input int s, input logic [23:0] pfx, input logic [15:0] prt);
        logic [39:0] e;
        e = {pfx, prt};
        for (int i = 0; i < 40; i++) begin
            int g;
            g = s*40 + i;
            mem[b*BEATS + g/WORD_W][g%WORD_W] = e[i];
        end
    endtask

    // Present a request at a negedge and hold it until accepted.
    task automatic send(input int b, input logic [23:0] key);
        req_valid  = 1'b1;
        req_bucket = BKT_W'(b);
        req_key    = key;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc_cyc   = cyc;
        req_valid = 1'b0;
    endtask

    // One lookup: send, wait for its response, and check it.
    task automatic lookup(input int b, input logic [23:0] key, input bit e_hit,
                          input int e_port, input string req);
        int idx;
        idx = n_rsp;
        send(b, key);
        while (n_rsp == idx) @(negedge clk);
        chk(log_hit[idx] == e_hit, {req, " hit"}, int'(log_hit[idx]), int'(e_hit));
        chk(log_port[idx] == 16'(e_port), {req, " port"}, int'(log_port[idx]), e_port);
        chk(log_cyc[idx] - acc_cyc == BEATS + 1, "R2 latency", log_cyc[idx] - acc_cyc, BEATS + 1);
    endtask

    task automatic t_reset();
        chk(!rsp_valid, "R9 rsp_valid", int'(rsp_valid), 0);
        chk(!mem_rd_en, "R9 mem_rd_en", int'(mem_rd_en), 0);
        chk(req_ready, "R9 req_ready", int'(req_ready), 1);
    endtask

    task automatic t_single_hit();
        int a0;
        clear_bucket(5);
        put_entry(5, 0, 24'hABCDEF, 16'h1234);
        a0 = n_rd;
        lookup(5, 24'hABCDEF, 1'b1, 16'h1234, "R4 slot0");
        chk(n_rd - a0 == BEATS, "R1 beat count", n_rd - a0, BEATS);
        for (int j = 0; j < BEATS; j++)
            chk(log_addr[a0 + j] == 5*BEATS + j, "R1 address", log_addr[a0 + j], 5*BEATS + j);
    endtask

    task automatic t_straddle();
        clear_bucket(9);
        put_entry(9, 1, 24'h123456, 16'hBEEF);
        put_entry(9, 3, 24'hF0F0F0, 16'h0A0B);
        put_entry(9, 4, 24'h00C0DE, 16'h4444);
        lookup(9, 24'h123456, 1'b1, 16'hBEEF, "R3 slot1 split");
        lookup(9, 24'hF0F0F0, 1'b1, 16'h0A0B, "R3 slot3 split");
        lookup(9, 24'h00C0DE, 1'b1, 16'h4444, "R3 slot4");
    endtask

    task automatic t_empty();
        clear_bucket(2);
        lookup(2, 24'h000000, 1'b0, 0, "R5 empty key0");
        clear_bucket(3);
        put_entry(3, 2, 24'h000000, 16'h0055);
        lookup(3, 24'h000000, 1'b1, 16'h0055, "R5 zero prefix");
    endtask

    task automatic t_priority();
        clear_bucket(7);
        put_entry(7, 3, 24'h777777, 16'h0033);
        put_entry(7, 1, 24'h777777, 16'h0011);
        put_entry(7, 4, 24'h777777, 16'h0044);
        lookup(7, 24'h777777, 1'b1, 16'h0011, "R6 lowest slot");
    endtask

    task automatic t_miss();
        lookup(9, 24'h123457, 1'b0, 0, "R7 miss");
    endtask

    task automatic t_back_to_back();
        int idx;
        idx = n_rsp;
        send(5, 24'hABCDEF);
        send(9, 24'hF0F0F0);
        while (n_rsp < idx + 2) @(negedge clk);
        chk(log_port[idx] == 16'h1234, "R8 first port", int'(log_port[idx]), 16'h1234);
        chk(log_port[idx+1] == 16'h0A0B, "R8 second port", int'(log_port[idx+1]), 16'h0A0B);
        chk(log_cyc[idx+1] - log_cyc[idx] == BEATS, "R8 spacing",
            log_cyc[idx+1] - log_cyc[idx], BEATS);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_hit();
        t_straddle();
        t_empty();
        t_priority();
        t_miss();
        t_back_to_back();
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule